// File: doc/BRIEF.md
# Banked Memory Decoder with Per-Bank Write Strobes

This block sits between a processor bus (20-bit address, 16-bit data) and a row of byte-wide memory devices. The data bus is split into two byte banks. The low bank uses bits 7..0 and the high bank uses bits 15..8. Address bit 0 low enables the low bank, and the active-low high-bank enable enables the high bank. A word access drives both enables low.

The block is purely combinational and uses one decoder. Seven address bits feed it. When the four most significant bits are all 1, the window F0000h-FFFFFh (64K bytes) is decoded. Address bits 15..13 then choose one of eight active-low chip selects, each covering 8K bytes: select k spans F0000h + k*2000h through F1FFFh + k*2000h.

The two banks are not served by two decoders. Each bank gets its own active-low write strobe instead, so any single byte or any word can be written. One active-low read strobe is shared by both banks; during a read both banks drive the bus and the processor discards the byte it does not need. Chip selects and strobes are only ever active during a memory cycle. Write and read strobes are never driven low together.

Top module: `mem_bank_decoder`

## Requirements
- R1: No chip select or strobe is low unless address bits 19..16 are all 1 (address F0000h or above).
- R2: Inside the window during a memory cycle, exactly one chip select is low: bit k of `cs_n_o`, where k is the value of address bits 15..13, equal to (address - F0000h) / 2000h.
- R3: With `mem_cyc_i` = 0 (I/O cycle), all chip selects and strobes are 1.
- R4: `rd_n_o` is 0 exactly when `rd_n_i` = 0, `wr_n_i` = 1, and the cycle is a decoded memory cycle.
- R5: `wr_lo_n_o` is 0 exactly when `wr_n_i` = 0, `rd_n_i` = 1, `addr_i[0]` = 0, and the cycle is a decoded memory cycle.
- R6: `wr_hi_n_o` is 0 exactly when `wr_n_i` = 0, `rd_n_i` = 1, `bhe_n_i` = 0, and the cycle is a decoded memory cycle.
- R7: A word write (`addr_i[0]` = 0 and `bhe_n_i` = 0) drives both bank write strobes low together. With both bank enables at 1, neither write strobe goes low.
- R8: When `rd_n_i` and `wr_n_i` are both 0, all three strobes stay 1, while the chip selects still follow R2. No output ever has the read strobe and a write strobe low at once.
- R9: While `rst_i` = 1, every output is 1 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Active-high reset; forces all outputs inactive |
| addr_i | input | 20 | Byte address; bit 0 low enables the low bank |
| bhe_n_i | input | 1 | Active-low high-bank enable |
| mem_cyc_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_n_i | input | 1 | Active-low read command |
| wr_n_i | input | 1 | Active-low write command |
| cs_n_o | output | 8 | Active-low chip selects, one per 8K region |
| rd_n_o | output | 1 | Active-low shared read strobe |
| wr_lo_n_o | output | 1 | Active-low low-bank write strobe |
| wr_hi_n_o | output | 1 | Active-low high-bank write strobe |

## Verification
The bench sweeps every combination of address bits 19..13, the high-bank enable, address bit 0, the cycle qualifier and both commands, with random low address bits. This shows that the chip-select index depends only on the upper address bits and that the window boundary is exact, with nothing decoded just below F0000h. Walking through the bank enables separates low-byte, high-byte and word writes. The command combinations separate idle, read, write and conflicting cycles. A second pass repeats sample patterns under reset to show that reset masks every output.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE     = 2'd0,
    CYC_READ     = 2'd1,
    CYC_WRITE    = 2'd2,
    CYC_CONFLICT = 2'd3
  } cyc_kind_e;

  // Turn the two active-low commands into a cycle kind.
  function automatic cyc_kind_e classify_cmd(logic rd_n, logic wr_n);
    case ({rd_n, wr_n})
      2'b01:   return CYC_READ;
      2'b10:   return CYC_WRITE;
      2'b00:   return CYC_CONFLICT;
      default: return CYC_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/mbd_window.sv
module mbd_window #(
  parameter int ADDR_W = 20,
  parameter int TAG_W  = 4
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  localparam logic [TAG_W-1:0] TAG_MATCH = '1;

  function automatic logic tag_hit(logic [TAG_W-1:0] t);
    return t == TAG_MATCH;
  endfunction

  assign hit_o = tag_hit(tag_i);

  initial begin
    if (TAG_W >= ADDR_W) $error("tag wider than address");
  end
endmodule

// File: rtl/mbd_cs_decode.sv
module mbd_cs_decode #(
  parameter int SEL_W = 3
) (
  input  logic                   en_i,
  input  logic [SEL_W-1:0]       sel_i,
  output logic [(1<<SEL_W)-1:0]  cs_n_o
);
  localparam int NUM_CS = 1 << SEL_W;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign cs_n_o[k] = ~(en_i && (sel_i == SEL_W'(k)));
  end

  always_comb begin
    // R2
    cs_single_chk: assert (!en_i || $countones(~cs_n_o) == 1);
    // R1
    cs_quiet_chk: assert (en_i || (&cs_n_o));
  end
endmodule

// File: rtl/mbd_strobes.sv
module mbd_strobes
  import mbd_pkg::*;
(
  input  logic      en_i,
  input  cyc_kind_e kind_i,
  input  logic      ble_n_i,
  input  logic      bhe_n_i,
  output logic      rd_n_o,
  output logic      wr_lo_n_o,
  output logic      wr_hi_n_o
);
  logic do_read;
  logic do_write;

  assign do_read   = en_i && (kind_i == CYC_READ);
  assign do_write  = en_i && (kind_i == CYC_WRITE);
  assign rd_n_o    = ~do_read;
  assign wr_lo_n_o = ~(do_write && !ble_n_i);
  assign wr_hi_n_o = ~(do_write && !bhe_n_i);

  always_comb begin
    // R8
    rd_wr_excl_chk: assert (rd_n_o || (wr_lo_n_o && wr_hi_n_o));
    // R8
    conflict_quiet_chk: assert (kind_i != CYC_CONFLICT || (rd_n_o && wr_lo_n_o && wr_hi_n_o));
  end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
  import mbd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int TAG_W  = 4,
  parameter int SEL_W  = 3
) (
  input  logic                  rst_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  bhe_n_i,
  input  logic                  mem_cyc_i,
  input  logic                  rd_n_i,
  input  logic                  wr_n_i,
  output logic [(1<<SEL_W)-1:0] cs_n_o,
  output logic                  rd_n_o,
  output logic                  wr_lo_n_o,
  output logic                  wr_hi_n_o
);
  localparam int SEL_LSB = ADDR_W - TAG_W - SEL_W;
  localparam logic [ADDR_W-1:0] WIN_BASE = {{TAG_W{1'b1}}, {(ADDR_W-TAG_W){1'b0}}};

  logic             win_hit;
  logic             dec_en;
  logic [SEL_W-1:0] region_sel;
  cyc_kind_e        cyc_kind;

  mbd_window #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_window (
    .tag_i (addr_i[ADDR_W-1 -: TAG_W]),
    .hit_o (win_hit)
  );

  assign dec_en     = win_hit && mem_cyc_i && !rst_i;
  assign region_sel = addr_i[SEL_LSB +: SEL_W];
  assign cyc_kind   = classify_cmd(rd_n_i, wr_n_i);

  mbd_cs_decode #(.SEL_W(SEL_W)) u_cs (
    .en_i   (dec_en),
    .sel_i  (region_sel),
    .cs_n_o (cs_n_o)
  );

  mbd_strobes u_strobes (
    .en_i      (dec_en),
    .kind_i    (cyc_kind),
    .ble_n_i   (addr_i[0]),
    .bhe_n_i   (bhe_n_i),
    .rd_n_o    (rd_n_o),
    .wr_lo_n_o (wr_lo_n_o),
    .wr_hi_n_o (wr_hi_n_o)
  );

  always_comb begin
    // R1
    win_range_chk: assert ((&cs_n_o) || addr_i >= WIN_BASE);
    // R9
    reset_idle_chk: assert (!rst_i || ((&cs_n_o) && rd_n_o && wr_lo_n_o && wr_hi_n_o));
    // R3
    io_idle_chk: assert (mem_cyc_i || ((&cs_n_o) && rd_n_o && wr_lo_n_o && wr_hi_n_o));
    // R5
    wr_lo_bank_chk: assert (wr_lo_n_o || (!addr_i[0] && !wr_n_i));
    // R6
    wr_hi_bank_chk: assert (wr_hi_n_o || (!bhe_n_i && !wr_n_i));
  end
endmodule

// File: tb/tb_mem_bank_decoder.sv
module tb_mem_bank_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_i;
  logic [19:0] addr_i;
  logic        bhe_n_i, mem_cyc_i, rd_n_i, wr_n_i;
  logic [7:0]  cs_n_o;
  logic        rd_n_o, wr_lo_n_o, wr_hi_n_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bank_decoder dut (
    .rst_i(rst_i), .addr_i(addr_i), .bhe_n_i(bhe_n_i), .mem_cyc_i(mem_cyc_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
    .wr_lo_n_o(wr_lo_n_o), .wr_hi_n_o(wr_hi_n_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h addr=%05h", req, act, exp, addr_i);
    end
  endtask

  // Behavioural reference: address arithmetic, not bit slicing.
  task automatic compare_all();
    int a;
    bit decoded, rd_on, wr_on;
    int idx;
    int exp_cs;
    a = int'(addr_i);
    decoded = !rst_i && mem_cyc_i && (a >= 'hF0000);
    idx = (a - 'hF0000) / 'h2000;
    exp_cs = 'hFF;
    if (decoded) exp_cs = 'hFF & ~(1 << idx);
    rd_on = decoded && !rd_n_i && wr_n_i;
    wr_on = decoded && !wr_n_i && rd_n_i;
    if (rst_i)             chk("R9 cs",  cs_n_o, exp_cs);
    else if (!mem_cyc_i)   chk("R3 cs",  cs_n_o, exp_cs);
    else if (a < 'hF0000)  chk("R1 cs",  cs_n_o, exp_cs);
    else                   chk("R2 cs",  cs_n_o, exp_cs);
    chk("R4 rd", rd_n_o, !rd_on);
    chk("R5 wr_lo", wr_lo_n_o, !(wr_on && addr_i[0] == 1'b0));
    chk("R6 wr_hi", wr_hi_n_o, !(wr_on && bhe_n_i == 1'b0));
    if (wr_on && !addr_i[0] && !bhe_n_i)
      chk("R7 word", {wr_lo_n_o, wr_hi_n_o}, 0);
    if (wr_on && addr_i[0] && bhe_n_i)
      chk("R7 none", {wr_lo_n_o, wr_hi_n_o}, 3);
    if (!rd_n_i && !wr_n_i)
      chk("R8 conflict", {rd_n_o, wr_lo_n_o, wr_hi_n_o}, 7);
    if (!rd_n_o && (!wr_lo_n_o || !wr_hi_n_o))
      chk("R8 excl", 1, 0);
  endtask

  task automatic apply(input bit rst, input int hi7, input int bits5);
    @(posedge clk);
    rst_i     = rst;
    addr_i    = {7'(hi7), 12'($urandom), bits5[3]};
    bhe_n_i   = bits5[4];
    mem_cyc_i = bits5[2];
    rd_n_i    = bits5[1];
    wr_n_i    = bits5[0];
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst_i = 1'b1; addr_i = '1; bhe_n_i = 1'b0; mem_cyc_i = 1'b1;
    rd_n_i = 1'b0; wr_n_i = 1'b1;
    @(negedge clk);
    chk("R9 reset cs", cs_n_o, 'hFF);
    chk("R9 reset strobes", {rd_n_o, wr_lo_n_o, wr_hi_n_o}, 7);
    for (int h = 0; h < 128; h++)
      for (int b = 0; b < 32; b++)
        apply(1'b0, h, b);
    for (int h = 120; h < 128; h++)
      for (int b = 0; b < 32; b += 3)
        apply(1'b1, h, b);
    // Window edges: just below and at the base, and the top address.
    @(posedge clk); rst_i = 0; mem_cyc_i = 1; rd_n_i = 1; wr_n_i = 0; bhe_n_i = 0;
    addr_i = 20'hEFFFE; @(negedge clk); chk("R1 below", cs_n_o, 'hFF); compare_all();
    @(posedge clk); addr_i = 20'hF0000; @(negedge clk); chk("R2 base", cs_n_o, 'hFE); compare_all();
    @(posedge clk); addr_i = 20'hFFFFE; @(negedge clk); chk("R2 top", cs_n_o, 'h7F); compare_all();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule